// File: doc/BRIEF.md
# L1 Victim Buffer

This block is a small fully-associative store that sits beside a 16 KiB, 4-way set-associative L1 data cache. It catches conflict misses without lengthening the L1 hit path. Whenever the L1 drops a line, it hands that line to the buffer together with its 50-bit physical line tag (a 56-bit physical address with a 64-byte line) and its dirty bit. The buffer is only searched after the L1 has already missed. The search compares the line tag against every valid entry in one cycle, and the answer comes back on the next cycle.

On a hit, the entry leaves the buffer and its data and dirty bit go back to the L1. The line that the L1 evicts to make room may be presented in the same cycle. That line then takes over the slot just freed, so the exchange is a single atomic swap.

When the buffer is full, an incoming line displaces an older entry. A displaced dirty entry becomes a write-back request toward memory. Further insertions are held off until that request is accepted. With eight entries, the entry array, the replacement pointer and the edge registers together stay well under 8192 bits of state.

Top module: `l1_victim_buffer`

## Requirements
- R1: After reset every entry is empty, `wb_valid` and `rsp_valid` are 0 and `ins_ready` is 1.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` high, and the lookup result is on the response outputs in that cycle.
- R3: A lookup that matches a valid entry returns `rsp_hit`=1 with that entry's index, data and dirty bit, and it removes the entry, so a repeat lookup of the same tag misses.
- R4: A lookup with no matching valid entry returns `rsp_hit`=0.
- R5: An accepted insertion goes into the lowest-numbered empty entry whenever one exists.
- R6: When all entries are valid and no swap is happening, an insertion replaces the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one after each such replacement. Without removals, this makes the replaced entry the one inserted longest ago.
- R7: Replacing a dirty entry raises `wb_valid` with that entry's tag and data. These are held unchanged until a cycle with `wb_ready` high, after which `wb_valid` drops. Replacing a clean entry raises no request.
- R8: While a write-back is pending, `ins_ready` is 0 and an insertion has no effect on the stored entries. Lookups are still served.
- R9: A lookup hit and an accepted insertion in the same cycle perform a swap. The new line is stored in the freed slot, no other entry is replaced, and no write-back is raised.
- R10: An accepted insertion and a lookup of the same tag in the same cycle report a hit carrying the inserted data and dirty bit, and the line is not kept in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An evicted L1 line is offered for insertion |
| ins_ready | output | 1 | Insertion can be accepted (no write-back pending) |
| ins_tag | input | 50 | Physical line tag of the offered line |
| ins_data | input | 512 | Data of the offered line |
| ins_dirty | input | 1 | Offered line is modified |
| lk_valid | input | 1 | Lookup request after an L1 miss |
| lk_tag | input | 50 | Physical line tag being looked up |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_idx | output | 3 | Entry that held the line |
| rsp_data | output | 512 | Returned line data (0 on miss) |
| rsp_dirty | output | 1 | Returned line was modified |
| wb_valid | output | 1 | Dirty line write-back request |
| wb_ready | input | 1 | Write-back request accepted this cycle |
| wb_tag | output | 50 | Line tag of the written-back line |
| wb_data | output | 512 | Data of the written-back line |

## Verification
Corrupted valid bits or tags show up on the very next lookup response, as a spurious hit, a missing hit or a wrong `rsp_idx`. A stale entry that a hit failed to remove is caught by repeating the lookup. A wrong replacement pointer stays hidden until the buffer is full, and then shows as the wrong tag on `wb_tag` or as the wrong entry missing on the following lookups. A write-back that is lost, or that changes while it waits, is visible on the write-back port while `wb_ready` is held low. Swaps and same-tag forwarding are checked in the response cycle and again with follow-up lookups that reveal what was stored.

// File: rtl/l1_victim_buffer.sv
module l1_victim_buffer #(
  parameter int ADDR_W     = 56,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8,
  localparam int TAG_W  = ADDR_W - $clog2(LINE_BYTES),
  localparam int DATA_W = LINE_BYTES * 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data
);

  logic [ENTRIES-1:0] valid, dirty, match;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [IDX_W-1:0]   ptr, hit_idx, free_idx, target;
  logic               free_any, lk_hit, ins_fire, fwd, full_repl, evict;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      match[i] = valid[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])  hit_idx  = IDX_W'(i);
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_any  = ~&valid;
  assign lk_hit    = lk_valid && |match;
  assign ins_ready = !wb_valid;
  assign ins_fire  = ins_valid && ins_ready;
  assign fwd       = ins_fire && lk_valid && (ins_tag == lk_tag);
  assign target    = lk_hit ? hit_idx : (free_any ? free_idx : ptr);
  assign full_repl = ins_fire && !fwd && !lk_hit && !free_any;
  assign evict     = full_repl && dirty[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
      ptr   <= '0;
    end else if (!fwd) begin
      if (lk_hit) valid[hit_idx] <= 1'b0;
      if (ins_fire) begin
        valid[target] <= 1'b1;
        dirty[target] <= ins_dirty;
      end
      if (full_repl) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire && !fwd) begin
      tag_q[target]  <= ins_tag;
      data_q[target] <= ins_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= fwd || lk_hit;
      rsp_idx   <= fwd ? target : hit_idx;
      rsp_data  <= fwd ? ins_data : (lk_hit ? data_q[hit_idx] : '0);
      rsp_dirty <= fwd ? ins_dirty : (lk_hit && dirty[hit_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_tag   <= '0;
      wb_data  <= '0;
    end else if (evict) begin
      wb_valid <= 1'b1;
      wb_tag   <= tag_q[ptr];
      wb_data  <= data_q[ptr];
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r3_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !ins_fire) |=> $countones(valid) == $countones($past(valid)) - 1);
  a_r5_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_fire && free_any && !lk_valid) |=> $countones(valid) == $countones($past(valid)) + 1);
  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> wb_valid && $stable(wb_tag) && $stable(wb_data));
  a_r8_stall_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_ready && !lk_valid) |=> $stable(valid));
  a_r9_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && ins_fire && !fwd) |=> $stable(valid) && !$rose(wb_valid));

endmodule

// File: tb/l1_victim_buffer_bench.sv
module l1_victim_buffer_bench;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ins_valid = 1'b0, ins_dirty = 1'b0, lk_valid = 1'b0, wb_ready = 1'b0;
  logic [49:0]  ins_tag = '0, lk_tag = '0;
  logic [511:0] ins_data = '0;
  logic         ins_ready, rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [2:0]   rsp_idx;
  logic [511:0] rsp_data, wb_data;
  logic [49:0]  wb_tag;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  l1_victim_buffer u_l1_victim_buffer (
    .clk, .rst_n, .ins_valid, .ins_ready, .ins_tag, .ins_data, .ins_dirty,
    .lk_valid, .lk_tag, .rsp_valid, .rsp_hit, .rsp_idx, .rsp_data, .rsp_dirty,
    .wb_valid, .wb_ready, .wb_tag, .wb_data
  );

  function automatic logic [511:0] mk(input logic [49:0] t);
    return {8{14'h1a5, t}};
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit iv, input logic [49:0] it, input bit id,
                      input bit lv, input logic [49:0] lt);
    @(negedge clk);
    ins_valid = iv; ins_tag = it; ins_data = mk(it); ins_dirty = id;
    lk_valid = lv;  lk_tag = lt;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0);
  endtask

  task automatic look(input logic [49:0] t, input bit hit, input logic [2:0] idx,
                      input bit dty, input string req);
    step(0, '0, 0, 1, t);
    chk({req, " rsp_valid"}, 512'(rsp_valid), 512'(1));
    chk({req, " rsp_hit"}, 512'(rsp_hit), 512'(hit));
    if (hit) begin
      chk({req, " rsp_idx"}, 512'(rsp_idx), 512'(idx));
      chk({req, " rsp_data"}, rsp_data, mk(t));
      chk({req, " rsp_dirty"}, 512'(rsp_dirty), 512'(dty));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ins_valid = 0; lk_valid = 0; wb_ready = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(input logic [49:0] base, input bit dmode);
    for (int i = 0; i < 8; i++) step(1, base + 50'(i), dmode ? 1'b1 : i[0], 0, '0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 ins_ready", 512'(ins_ready), 512'(1));
    chk("R1 wb_valid", 512'(wb_valid), 512'(0));
    chk("R1 rsp_valid", 512'(rsp_valid), 512'(0));
    look(50'h5, 0, 0, 0, "R1 empty");
  endtask

  task automatic t_basic();
    do_reset();
    step(1, 50'h77, 0, 0, '0);
    idle();
    chk("R2 no rsp without lookup", 512'(rsp_valid), 512'(0));
    look(50'h78, 0, 0, 0, "R4 miss");
    look(50'h77, 1, 0, 0, "R3 hit");
    look(50'h77, 0, 0, 0, "R3 removed");
  endtask

  task automatic t_fill();
    do_reset();
    fill(50'h100, 0);
    look(50'h103, 1, 3, 1, "R5 fill order");
    step(1, 50'h200, 0, 0, '0);
    look(50'h200, 1, 3, 0, "R5 lowest free slot");
    look(50'h106, 1, 6, 0, "R5 fill order");
  endtask

  task automatic t_replace();
    do_reset();
    fill(50'h300, 0);
    step(1, 50'h310, 0, 0, '0);
    chk("R7 clean victim no wb", 512'(wb_valid), 512'(0));
    step(1, 50'h312, 0, 0, '0);
    look(50'h300, 0, 0, 0, "R6 oldest replaced");
    look(50'h301, 0, 0, 0, "R6 pointer advanced");
    look(50'h312, 1, 1, 0, "R6 slot1 reused");
    look(50'h310, 1, 0, 0, "R6 slot0 reused");
    look(50'h302, 1, 2, 0, "R6 others kept");
  endtask

  task automatic t_writeback();
    do_reset();
    fill(50'h400, 1);
    step(1, 50'h410, 0, 0, '0);
    chk("R7 wb raised", 512'(wb_valid), 512'(1));
    chk("R7 wb tag", 512'(wb_tag), 512'(50'h400));
    chk("R7 wb data", wb_data, mk(50'h400));
    chk("R8 ins_ready low", 512'(ins_ready), 512'(0));
    step(1, 50'h420, 0, 1, 50'h420);
    chk("R8 rejected insert no fwd", 512'(rsp_hit), 512'(0));
    idle(); idle();
    chk("R7 wb held", 512'(wb_valid), 512'(1));
    chk("R7 wb tag held", 512'(wb_tag), 512'(50'h400));
    look(50'h420, 0, 0, 0, "R8 insert ignored");
    look(50'h401, 1, 1, 1, "R8 lookup served");
    @(negedge clk); wb_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); wb_ready = 1'b0;
    #1;
    chk("R7 wb dropped", 512'(wb_valid), 512'(0));
    chk("R7 ins_ready back", 512'(ins_ready), 512'(1));
    look(50'h410, 1, 0, 0, "R7 new line stored");
  endtask

  task automatic t_swap();
    do_reset();
    fill(50'h500, 0);
    step(1, 50'h5aa, 1, 1, 50'h505);
    chk("R9 swap hit", 512'(rsp_hit), 512'(1));
    chk("R9 swap idx", 512'(rsp_idx), 512'(5));
    chk("R9 swap data", rsp_data, mk(50'h505));
    chk("R9 no wb", 512'(wb_valid), 512'(0));
    look(50'h5aa, 1, 5, 1, "R9 new line in freed slot");
    look(50'h500, 1, 0, 0, "R9 no replacement");
  endtask

  task automatic t_forward();
    do_reset();
    step(1, 50'h600, 1, 1, 50'h600);
    chk("R10 fwd hit", 512'(rsp_hit), 512'(1));
    chk("R10 fwd data", rsp_data, mk(50'h600));
    chk("R10 fwd dirty", 512'(rsp_dirty), 512'(1));
    look(50'h600, 0, 0, 0, "R10 not retained");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_fill();
    t_replace();
    t_writeback();
    t_swap();
    t_forward();
    finish_run();
  end

  initial begin
    #(PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule